// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects a parameterised set of level-sensitive interrupt request lines and offers the CPU at most one of them at a time. Each line has an enable bit and an 8-bit priority byte. Only the upper bits of the byte are stored. A lower stored value means a more urgent line. The block latches requests into pending bits and picks the most urgent pending, enabled and unmasked line. It then decides whether that line may interrupt the handler that is already running.

A grouping setting divides the stored priority bits into two fields. The upper field is the preemption level, and only this field decides whether one handler may interrupt another. The lower field is the sub-priority, which only orders requests that are waiting at the same time. A threshold setting hides every line whose stored priority is at the threshold or less urgent. When the CPU acknowledges the offered line, that line's pending bit is cleared and its priority is pushed onto a stack of active levels. An end-of-interrupt pops the stack. The running level is always the top of the stack, and the block is idle when the stack is empty.

Software reaches the settings through a small write/read port. A selector picks the priority byte of a line, the enable bit of a line, the grouping value, or the threshold.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A priority byte read back (selector 0) returns the written upper PRIO_BITS bits, and its low 8-PRIO_BITS bits are always zero. A threshold read (selector 3) behaves the same way.
- R2: Among the eligible lines, the one with the numerically smallest stored priority is offered on irq_id.
- R3: When two eligible lines have the same stored priority, the lower line number is offered.
- R4: The grouping value (selector 2, bits 3:0) gives the number of sub-priority bits, from 0 to PRIO_BITS. A larger write is stored as PRIO_BITS, and the stored value reads back.
- R5: While a handler is active, a line is offered only if its preemption field (stored priority shifted right by the grouping value) is strictly smaller than that of the top active level.
- R6: A nonzero threshold blocks every line whose stored priority is greater than or equal to it. A threshold of zero blocks nothing.
- R7: A line whose enable bit (selector 1, bit 0) is clear is never offered, but its pending bit is kept. The line is offered once it is enabled again.
- R8: cpu_ack while irq_valid is high clears that line's pending bit and pushes its priority. In the next cycle irq_valid is low, run_idle is low and run_prio equals the acknowledged priority.
- R9: cpu_eoi pops the active stack, so run_prio returns to the level below, or run_idle rises when the stack empties. An end-of-interrupt with an empty stack has no effect.
- R10: irq_valid, irq_id and irq_prio are registered. They reflect the pending, enable, priority, threshold and stack state of the previous cycle, and a request is latched into its pending bit at the clock edge where it is sampled high.
- R11: After reset, nothing is offered, the block is idle, and all priorities, enables, the grouping and the threshold read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_IRQ | Level-sensitive request lines |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 2 | Setting selector: 0 priority, 1 enable, 2 grouping, 3 threshold |
| cfg_idx | input | IDX_W | Line number for selectors 0 and 1 |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for the current selector and index |
| irq_valid | output | 1 | A line is offered to the CPU |
| irq_id | output | IDX_W | Number of the offered line |
| irq_prio | output | 8 | Priority byte of the offered line |
| cpu_ack | input | 1 | CPU takes the offered line |
| cpu_eoi | input | 1 | CPU finishes the running handler |
| run_idle | output | 1 | No handler is active |
| run_prio | output | 8 | Priority byte of the running handler, zero when idle |

## Verification
The bench goes after the cases where urgency is decided by something other than the plain priority value. In one case two lines share a level, and a design that breaks the tie the wrong way offers the higher line number. In another, two levels differ only in their sub-priority field, and a design that nests on the whole value lets a same-group request interrupt the running handler. The threshold is tested at exactly its own level, where an off-by-one comparison leaks one level. A disabled line is left pending and enabled again later, where a design that drops the pending bit never raises the interrupt. The acknowledge and end-of-interrupt steps are checked on the cycle they take effect: a stale offer after an acknowledge would raise the same line twice, and an unguarded pop on an empty stack would corrupt the running level.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        SEL_PRIO   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_GROUP  = 2'd2,
        SEL_THRESH = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int NUM_IRQ   = 8,
    parameter int PRIO_BITS = 4,
    localparam int IDX_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio,
    input  logic [NUM_IRQ-1:0]                elig,
    output logic                              found,
    output logic [IDX_W-1:0]                  win_id,
    output logic [PRIO_BITS-1:0]              win_prio
);

    // ascending scan with strict compare: equal levels keep the lower number
    always_comb begin
        found    = 1'b0;
        win_id   = '0;
        win_prio = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (elig[i] && (!found || (prio[i] < win_prio))) begin
                found    = 1'b1;
                win_id   = IDX_W'(i);
                win_prio = prio[i];
            end
        end
    end

endmodule

// File: rtl/irqc_stack.sv
module irqc_stack #(
    parameter int PRIO_BITS   = 4,
    parameter int STACK_DEPTH = 16,
    localparam int AW = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1,
    localparam int CW = $clog2(STACK_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic                 pop,
    input  logic [PRIO_BITS-1:0] push_prio,
    output logic [PRIO_BITS-1:0] top_prio,
    output logic                 empty
);

    localparam logic [CW-1:0] FULL = CW'(STACK_DEPTH);

    typedef struct packed {
        logic [STACK_DEPTH-1:0][PRIO_BITS-1:0] mem;
        logic [CW-1:0]                         cnt;
    } stk_t;

    stk_t s_d, s_q;

    logic          do_pop, do_push;
    logic [AW-1:0] top_idx, next_idx;

    assign top_idx  = AW'(s_q.cnt - 1'b1);
    assign next_idx = AW'(s_q.cnt);
    assign empty    = (s_q.cnt == '0);
    assign top_prio = empty ? '0 : s_q.mem[top_idx];

    always_comb begin
        s_d     = s_q;
        do_pop  = pop && !empty;
        do_push = push && ((s_q.cnt != FULL) || do_pop);
        if (do_pop && do_push) begin
            s_d.mem[top_idx] = push_prio;
        end else if (do_pop) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end else if (do_push) begin
            s_d.mem[next_idx] = push_prio;
            s_d.cnt           = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ     = 8,
    parameter int PRIO_BITS   = 4,
    parameter int STACK_DEPTH = 16,
    localparam int IDX_W      = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    output logic               irq_valid,
    output logic [IDX_W-1:0]   irq_id,
    output logic [7:0]         irq_prio,
    input  logic               cpu_ack,
    input  logic               cpu_eoi,
    output logic               run_idle,
    output logic [7:0]         run_prio
);

    localparam int GW    = $clog2(PRIO_BITS + 1);
    localparam int LOW_W = 8 - PRIO_BITS;

    localparam logic [GW-1:0]    GRP_MAX  = GW'(PRIO_BITS);
    localparam logic [7:0]       GRP_MAX8 = 8'(PRIO_BITS);
    localparam logic [IDX_W:0]   NUM_L    = (IDX_W + 1)'(NUM_IRQ);

    typedef struct packed {
        logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio;
        logic [NUM_IRQ-1:0]                en;
        logic [NUM_IRQ-1:0]                pend;
        logic [GW-1:0]                     grp;
        logic [PRIO_BITS-1:0]              thr;
        logic                              valid;
        logic [IDX_W-1:0]                  id;
        logic [PRIO_BITS-1:0]              sprio;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_IRQ-1:0]   elig;
    logic                 found;
    logic [IDX_W-1:0]     win_id;
    logic [PRIO_BITS-1:0] win_prio;
    logic [PRIO_BITS-1:0] top_prio;
    logic                 stk_empty;
    logic                 ack_fire, eoi_fire, may_offer, idx_ok;
    logic [NUM_IRQ-1:0]   ack_clr;
    cfg_sel_e             sel;

    // signals brought out for the bound checker
    logic [GW-1:0]        grp_w;
    logic [PRIO_BITS-1:0] thr_w;
    logic [PRIO_BITS-1:0] top_w;
    assign grp_w = st_q.grp;
    assign thr_w = st_q.thr;
    assign top_w = top_prio;

    assign sel    = cfg_sel_e'(cfg_sel);
    assign idx_ok = ({1'b0, cfg_idx} < NUM_L);

    // per-line gating: pending, enabled and not masked by the threshold
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_elig
        assign elig[g] = st_q.pend[g] && st_q.en[g] &&
                         ((st_q.thr == '0) || (st_q.prio[g] < st_q.thr));
    end

    irqc_arbiter #(
        .NUM_IRQ  (NUM_IRQ),
        .PRIO_BITS(PRIO_BITS)
    ) u_arb (
        .prio    (st_q.prio),
        .elig    (elig),
        .found   (found),
        .win_id  (win_id),
        .win_prio(win_prio)
    );

    assign ack_fire = cpu_ack && st_q.valid;
    assign eoi_fire = cpu_eoi && !stk_empty;

    irqc_stack #(
        .PRIO_BITS  (PRIO_BITS),
        .STACK_DEPTH(STACK_DEPTH)
    ) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ack_fire),
        .pop      (cpu_eoi),
        .push_prio(st_q.sprio),
        .top_prio (top_prio),
        .empty    (stk_empty)
    );

    // nesting is decided by the preemption field alone
    assign may_offer = found &&
                       (stk_empty || ((win_prio >> st_q.grp) < (top_prio >> st_q.grp)));

    always_comb begin
        ack_clr = '0;
        if (ack_fire) begin
            ack_clr[st_q.id] = 1'b1;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend | irq_req) & ~ack_clr;
        if (cfg_we) begin
            unique case (sel)
                SEL_PRIO: begin
                    if (idx_ok) st_d.prio[cfg_idx] = cfg_wdata[7 -: PRIO_BITS];
                end
                SEL_ENABLE: begin
                    if (idx_ok) st_d.en[cfg_idx] = cfg_wdata[0];
                end
                SEL_GROUP: begin
                    st_d.grp = (cfg_wdata > GRP_MAX8) ? GRP_MAX : cfg_wdata[GW-1:0];
                end
                SEL_THRESH: begin
                    st_d.thr = cfg_wdata[7 -: PRIO_BITS];
                end
                default: ;
            endcase
        end
        // a stale offer must not survive an acknowledge or a level change
        st_d.valid = may_offer && !ack_fire && !eoi_fire;
        st_d.id    = win_id;
        st_d.sprio = win_prio;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (sel)
            SEL_PRIO:   if (idx_ok) cfg_rdata = 8'(st_q.prio[cfg_idx]) << LOW_W;
            SEL_ENABLE: if (idx_ok) cfg_rdata = {7'd0, st_q.en[cfg_idx]};
            SEL_GROUP:  cfg_rdata = 8'(st_q.grp);
            SEL_THRESH: cfg_rdata = 8'(st_q.thr) << LOW_W;
            default:    cfg_rdata = '0;
        endcase
    end

    assign irq_valid = st_q.valid;
    assign irq_id    = st_q.id;
    assign irq_prio  = 8'(st_q.sprio) << LOW_W;
    assign run_idle  = stk_empty;
    assign run_prio  = 8'(top_prio) << LOW_W;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int NUM_IRQ   = 8,
    parameter int PRIO_BITS = 4,
    localparam int IDX_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
    localparam int GW       = $clog2(PRIO_BITS + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 irq_valid,
    input logic [IDX_W-1:0]     irq_id,
    input logic [7:0]           irq_prio,
    input logic                 cpu_ack,
    input logic                 cpu_eoi,
    input logic                 run_idle,
    input logic [7:0]           run_prio,
    input logic [1:0]           cfg_sel,
    input logic [7:0]           cfg_rdata,
    input logic [GW-1:0]        grp_w,
    input logic [PRIO_BITS-1:0] thr_w,
    input logic [PRIO_BITS-1:0] top_w
);

    localparam int LOW_W = 8 - PRIO_BITS;

    logic [PRIO_BITS-1:0] offer_lvl;
    assign offer_lvl = irq_prio[7 -: PRIO_BITS];

    p_low_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == 2'd0) |-> ((cfg_rdata & ((8'd1 << LOW_W) - 8'd1)) == 8'd0));

    p_group_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == 2'd2) |-> (cfg_rdata <= 8'(PRIO_BITS)));

    p_preempt_strict_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !run_idle) |-> ((offer_lvl >> grp_w) < (top_w >> grp_w)));

    p_thresh_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && (thr_w != '0)) |-> (offer_lvl < thr_w));

    p_id_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (int'(irq_id) < NUM_IRQ));

    p_ack_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && cpu_ack && !cpu_eoi) |=> (!irq_valid && !run_idle && (run_prio == $past(irq_prio))));

    p_eoi_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_idle && cpu_eoi && !(irq_valid && cpu_ack)) |=> run_idle);

endmodule

bind prio_irq_ctrl irqc_checker #(
    .NUM_IRQ  (NUM_IRQ),
    .PRIO_BITS(PRIO_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_valid(irq_valid),
    .irq_id   (irq_id),
    .irq_prio (irq_prio),
    .cpu_ack  (cpu_ack),
    .cpu_eoi  (cpu_eoi),
    .run_idle (run_idle),
    .run_prio (run_prio),
    .cfg_sel  (cfg_sel),
    .cfg_rdata(cfg_rdata),
    .grp_w    (grp_w),
    .thr_w    (thr_w),
    .top_w    (top_w)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/100ps
module prio_irq_ctrl_bench;

    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [IW-1:0] cfg_idx = '0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic          irq_valid;
    logic [IW-1:0] irq_id;
    logic [7:0]    irq_prio;
    logic          cpu_ack = 1'b0;
    logic          cpu_eoi = 1'b0;
    logic          run_idle;
    logic [7:0]    run_prio;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl #(.NUM_IRQ(N), .PRIO_BITS(4), .STACK_DEPTH(16)) u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq_valid(irq_valid), .irq_id(irq_id), .irq_prio(irq_prio),
        .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi), .run_idle(run_idle), .run_prio(run_prio)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_prio[N];
    bit m_en[N];
    bit m_pend[N];
    int m_grp, m_thr;
    bit m_valid;
    int m_id, m_sp;
    int m_stk[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_prio[i]) begin m_prio[i] = 0; m_en[i] = 0; m_pend[i] = 0; end
            m_grp = 0; m_thr = 0; m_valid = 0; m_id = 0; m_sp = 15;
            m_stk.delete();
        end else begin
            bit fire, efire, bf, ok;
            int bp, bi;
            fire = m_valid && cpu_ack;
            efire = cpu_eoi && (m_stk.size() > 0);
            bf = 0; bp = 15; bi = 0;
            for (int i = 0; i < N; i++) begin
                if (m_pend[i] && m_en[i] && (m_thr == 0 || m_prio[i] < m_thr) &&
                    (!bf || m_prio[i] < bp)) begin
                    bf = 1; bp = m_prio[i]; bi = i;
                end
            end
            ok = bf && (m_stk.size() == 0 || (bp >> m_grp) < (m_stk[$] >> m_grp));
            if (efire) void'(m_stk.pop_back());
            if (fire) m_stk.push_back(m_sp);
            for (int i = 0; i < N; i++) m_pend[i] = m_pend[i] | irq_req[i];
            if (fire) m_pend[m_id] = 0;
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: m_prio[cfg_idx] = cfg_wdata >> 4;
                    2'd1: m_en[cfg_idx] = cfg_wdata[0];
                    2'd2: m_grp = (cfg_wdata > 4) ? 4 : cfg_wdata;
                    default: m_thr = cfg_wdata >> 4;
                endcase
            end
            m_valid = ok && !fire && !efire;
            m_id = bi; m_sp = bp;
        end
    end

    // compare every cycle, between edges
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            int exp_rd, exp_run;
            check(irq_valid == m_valid, "R10 offer valid", irq_valid, m_valid);
            if (m_valid) begin
                check(irq_id == m_id, "R2 offered line", irq_id, m_id);
                check(irq_prio == (m_sp << 4), "R2 offered level", irq_prio, m_sp << 4);
            end
            exp_run = (m_stk.size() == 0) ? 0 : (m_stk[$] << 4);
            check(run_idle == (m_stk.size() == 0), "R9 idle", run_idle, m_stk.size() == 0);
            check(run_prio == exp_run, "R9 running level", run_prio, exp_run);
            case (cfg_sel)
                2'd0: exp_rd = m_prio[cfg_idx] << 4;
                2'd1: exp_rd = m_en[cfg_idx];
                2'd2: exp_rd = m_grp;
                default: exp_rd = m_thr << 4;
            endcase
            check(cfg_rdata == exp_rd, "R1 readback", cfg_rdata, exp_rd);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int sel, input int idx, input int val);
        @(negedge clk);
        cfg_we = 1; cfg_sel = 2'(sel); cfg_idx = IW'(idx); cfg_wdata = 8'(val);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic rd(input int sel, input int idx, output int val);
        @(negedge clk);
        cfg_sel = 2'(sel); cfg_idx = IW'(idx);
        #1 val = cfg_rdata;
    endtask

    task automatic pulse_req(input logic [N-1:0] m);
        @(negedge clk); irq_req = m;
        @(negedge clk); irq_req = '0;
    endtask

    task automatic ack();
        @(negedge clk); cpu_ack = 1;
        @(negedge clk); cpu_ack = 0;
    endtask

    task automatic eoi();
        @(negedge clk); cpu_eoi = 1;
        @(negedge clk); cpu_eoi = 0;
    endtask

    initial begin
        int v;
        tick(3);
        rst_n = 1;
        tick(2);
        // R11 reset state
        check(!irq_valid && run_idle, "R11 idle after reset", {irq_valid, run_idle}, 1);
        rd(0, 5, v); check(v == 0, "R11 priority zero", v, 0);
        rd(3, 0, v); check(v == 0, "R11 threshold zero", v, 0);

        // R1 low bits read as zero
        wr(0, 2, 8'hFF); rd(0, 2, v); check(v == 8'hF0, "R1 prio FF", v, 8'hF0);
        wr(0, 2, 8'h37); rd(0, 2, v); check(v == 8'h30, "R1 prio 37", v, 8'h30);
        // R4 grouping clamp
        wr(2, 0, 7); rd(2, 0, v); check(v == 4, "R4 clamp", v, 4);
        wr(2, 0, 0); rd(2, 0, v); check(v == 0, "R4 zero", v, 0);

        for (int i = 0; i < N; i++) wr(1, i, 1);
        wr(0, 3, 8'h50); wr(0, 5, 8'h30); wr(0, 1, 8'h10);
        wr(0, 4, 8'h20); wr(0, 6, 8'h20); wr(0, 0, 8'hE0); wr(0, 7, 8'hE0);

        // R2 most urgent wins
        pulse_req(8'b0010_1000); tick(1);
        check(irq_valid && irq_id == 5, "R2 line 5 wins", irq_id, 5);
        // R8 acknowledge
        ack();
        check(!irq_valid, "R8 offer drops", irq_valid, 0);
        check(run_prio == 8'h30 && !run_idle, "R8 running 30", run_prio, 8'h30);
        tick(2);
        // R5 less urgent line waits
        check(!irq_valid, "R5 no preempt by 50", irq_valid, 0);
        pulse_req(8'b0000_0010); tick(1);
        check(irq_valid && irq_id == 1, "R5 line 1 preempts", irq_id, 1);
        ack(); tick(1);
        check(run_prio == 8'h10, "R8 nested 10", run_prio, 8'h10);
        // R9 pop back
        eoi(); tick(1);
        check(run_prio == 8'h30, "R9 back to 30", run_prio, 8'h30);
        eoi(); tick(1);
        check(irq_valid && irq_id == 3, "R9 line 3 after idle", irq_id, 3);
        ack(); eoi(); tick(1);
        check(run_idle, "R9 idle", run_idle, 1);
        eoi(); tick(1);
        check(run_idle && run_prio == 0, "R9 eoi on empty", run_prio, 0);

        // R3 tie
        pulse_req(8'b0101_0000); tick(1);
        check(irq_valid && irq_id == 4, "R3 lower number", irq_id, 4);
        ack(); eoi(); tick(1);
        check(irq_valid && irq_id == 6, "R3 line 6 next", irq_id, 6);
        ack(); eoi(); tick(2);

        // R5 grouping 2: 0x40 active, 0x50 same group, 0x30 lower group
        wr(2, 0, 2);
        wr(0, 2, 8'h40); wr(0, 3, 8'h50); wr(0, 5, 8'h30);
        pulse_req(8'b0000_0100); tick(1); ack(); tick(1);
        pulse_req(8'b0000_1000); tick(2);
        check(!irq_valid, "R5 same group blocked", irq_valid, 0);
        pulse_req(8'b0010_0000); tick(1);
        check(irq_valid && irq_id == 5, "R5 lower group preempts", irq_id, 5);
        ack(); eoi(); tick(1); eoi(); tick(1);
        check(irq_valid && irq_id == 3, "R5 waiting line after", irq_id, 3);
        ack(); eoi(); tick(2);
        wr(2, 0, 0);

        // R6 threshold
        wr(3, 0, 8'h50);
        wr(0, 3, 8'h50); pulse_req(8'b0000_1000); tick(2);
        check(!irq_valid, "R6 level equal masked", irq_valid, 0);
        wr(0, 3, 8'h40); tick(1);
        check(irq_valid && irq_id == 3, "R6 below threshold", irq_id, 3);
        wr(0, 3, 8'h90); tick(1);
        check(!irq_valid, "R6 masked again", irq_valid, 0);
        wr(3, 0, 0); tick(1);
        check(irq_valid && irq_id == 3, "R6 zero disables", irq_id, 3);
        ack(); eoi(); tick(2);

        // R7 disabled line keeps pending
        wr(1, 7, 0);
        pulse_req(8'b1000_0000); tick(3);
        check(!irq_valid, "R7 disabled", irq_valid, 0);
        wr(1, 7, 1); tick(1);
        check(irq_valid && irq_id == 7, "R7 enabled later", irq_id, 7);
        ack(); eoi(); tick(3);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule